// File: doc/BRIEF.md
# Hiccup Soft-Start Supervisor

This block supervises the start-up of a group of linear regulators that share one soft-start reference. Once the upstream main rail reports that it is in regulation, the supervisor produces a digital reference code in millivolts that climbs from zero to the final regulation level over a fixed interval. Each regulator's output arrives as a digitised feedback code in millivolts. The ramp ends at the reference, and the supervisor then waits for every feedback to settle inside a window around it.

While the ramp or the settling wait is running, every channel is compared against the ramp. A channel that trails the ramp by the short-circuit margin or more is taken as a short or a failed supply. The supervisor then drops the shared ramp to zero for all channels and starts the soft-start over, a hiccup. It counts hiccups in a saturating counter. When all channels are inside the window, the block declares regulation, holds the reference at its final value and stops checking for lag. When the upstream signal drops, the block returns to idle at once.

The ramp step and tick period are derived at elaboration from the clock rate, the ramp duration and the step size, so the ramp spans the requested time.

Top module: `ss_hiccup_supervisor`

## Requirements
- R1: After reset `ramp_mv` is 0, and `soft_active`, `regulated`, `restart` and `hiccup_cnt` are all 0.
- R2: While `main_ok` is low the block stays idle: `ramp_mv` stays 0 and `soft_active` and `regulated` stay low, whatever the feedback values are.
- R3: One clock edge after `main_ok` rises, `soft_active` goes high with `ramp_mv` at 0. The ramp then rises by STEP_MV once every TICK_CYCLES cycles and never exceeds REF_MV. It reaches REF_MV STEPS*TICK_CYCLES edges after start, where STEPS = REF_MV/STEP_MV, and then holds there.
- R4: While `soft_active` is high, if any channel's feedback satisfies ramp − feedback ≥ MARGIN_MV, then on the next edge `ramp_mv` returns to 0, `restart` pulses and the ramp starts again from the beginning. A lag of MARGIN_MV−1 causes no restart. Channel c occupies bits `fb_mv[c*FB_W +: FB_W]`.
- R5: `hiccup_cnt` increases by one on each restart and saturates at 2^CNT_W−1. Only reset clears it; it is kept when `main_ok` drops.
- R6: Once `ramp_mv` has reached REF_MV, `regulated` rises on the edge after every feedback lies within REF_MV−WIN_MV to REF_MV+WIN_MV, both limits included. `soft_active` falls at the same edge.
- R7: While `regulated` is high, feedback has no effect: `ramp_mv` stays at REF_MV, `regulated` stays high and no restart occurs.
- R8: A low `main_ok` sampled at an edge returns the block to idle at that edge, from any state.
- R9: `restart` is high for exactly one cycle for each detected lag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_ok | input | 1 | Upstream main rail in regulation; enables the supervisor |
| fb_mv | input | NUM_CH*FB_W | Feedback codes in millivolts, channel c in bits c*FB_W upward |
| ramp_mv | output | FB_W | Shared soft-start reference code in millivolts |
| soft_active | output | 1 | Ramp or settling wait in progress; lag checking enabled |
| regulated | output | 1 | All channels in regulation; reference held at REF_MV |
| restart | output | 1 | One-cycle pulse marking a hiccup restart |
| hiccup_cnt | output | CNT_W | Saturating count of restarts since reset |

## Verification
The assertions assume that `main_ok` and the feedback codes are synchronous to `clk`, stable around the rising edge, and within FB_W bits. They also assume MARGIN_MV is non-zero, so two restarts can never fall on adjacent cycles. The bench changes every input on the falling edge and keeps all feedback codes between 0 and REF_MV+WIN_MV. It exercises lag exactly at and one below the margin, window limits on both sides, and a fault that persists long enough to saturate the counter.

// File: rtl/ss_pkg.sv
package ss_pkg;
   typedef enum logic [1:0] {
      SS_IDLE   = 2'd0,
      SS_RAMP   = 2'd1,
      SS_SETTLE = 2'd2,
      SS_HOLD   = 2'd3
   } ss_state_e;
endpackage

// File: rtl/ss_tick_gen.sv
module ss_tick_gen #(
   parameter int TICK_CYCLES = 1500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   if (TICK_CYCLES < 1) begin : g_bad_tick
      $error("ss_tick_gen: TICK_CYCLES must be at least 1");
   end

   if (TICK_CYCLES == 1) begin : g_every
      assign tick = run;
   end else begin : g_count
      localparam int CW = $clog2(TICK_CYCLES);
      localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n || !run) begin
            cnt_q <= '0;
         end else if (cnt_q == LAST) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign tick = run && (cnt_q == LAST);
   end
endmodule

// File: rtl/ss_lag_det.sv
module ss_lag_det #(
   parameter int FB_W      = 12,
   parameter int REF_MV    = 800,
   parameter int MARGIN_MV = 100,
   parameter int WIN_MV    = 24
) (
   input  logic [FB_W-1:0] ramp_mv,
   input  logic [FB_W-1:0] fb_mv,
   output logic            lag,
   output logic            in_win
);
   if (WIN_MV > REF_MV) begin : g_bad_win
      $error("ss_lag_det: WIN_MV must not exceed REF_MV");
   end

   localparam logic [FB_W:0]   MARGIN_C = (FB_W+1)'(MARGIN_MV);
   localparam logic [FB_W-1:0] WIN_LO   = FB_W'(REF_MV - WIN_MV);
   localparam logic [FB_W-1:0] WIN_HI   = FB_W'(REF_MV + WIN_MV);

   logic [FB_W:0] fb_plus_margin;

   always_comb begin
      fb_plus_margin = {1'b0, fb_mv} + MARGIN_C;
      lag            = ({1'b0, ramp_mv} >= fb_plus_margin);
      in_win         = (fb_mv >= WIN_LO) && (fb_mv <= WIN_HI);
   end
endmodule

// File: rtl/ss_sat_cnt.sv
module ss_sat_cnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   if (CNT_W < 1) begin : g_bad_w
      $error("ss_sat_cnt: CNT_W must be at least 1");
   end

   localparam logic [CNT_W-1:0] TOP = '1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (inc && (count != TOP)) begin
         count <= count + 1'b1;
      end
   end
endmodule

// File: rtl/ss_hiccup_supervisor.sv
module ss_hiccup_supervisor
   import ss_pkg::*;
#(
   parameter int NUM_CH    = 2,
   parameter int FB_W      = 12,
   parameter int CLK_KHZ   = 100000,
   parameter int RAMP_US   = 1500,
   parameter int REF_MV    = 800,
   parameter int STEP_MV   = 8,
   parameter int MARGIN_MV = 100,
   parameter int WIN_MV    = 24,
   parameter int CNT_W     = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   main_ok,
   input  logic [NUM_CH*FB_W-1:0] fb_mv,
   output logic [FB_W-1:0]        ramp_mv,
   output logic                   soft_active,
   output logic                   regulated,
   output logic                   restart,
   output logic [CNT_W-1:0]       hiccup_cnt
);
   localparam int STEPS       = REF_MV / STEP_MV;
   localparam int TICK_CYCLES = (CLK_KHZ * RAMP_US) / (1000 * STEPS);
   localparam logic [FB_W-1:0] STEP_C    = FB_W'(STEP_MV);
   localparam logic [FB_W-1:0] LAST_STEP = FB_W'(REF_MV - STEP_MV);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("ss_hiccup_supervisor: NUM_CH must be at least 1");
   end
   if (STEP_MV < 1 || (REF_MV % STEP_MV) != 0) begin : g_bad_step
      $error("ss_hiccup_supervisor: STEP_MV must divide REF_MV");
   end
   if (MARGIN_MV < 1) begin : g_bad_margin
      $error("ss_hiccup_supervisor: MARGIN_MV must be positive");
   end
   if (REF_MV + WIN_MV >= (1 << FB_W)) begin : g_bad_width
      $error("ss_hiccup_supervisor: FB_W too narrow for REF_MV+WIN_MV");
   end
   if (TICK_CYCLES < 1) begin : g_bad_time
      $error("ss_hiccup_supervisor: ramp interval shorter than its step count");
   end

   ss_state_e       state_q;
   logic [FB_W-1:0] ramp_q;
   logic            restart_q;
   logic [NUM_CH-1:0] lag_vec;
   logic [NUM_CH-1:0] win_vec;
   logic            checking;
   logic            fault;
   logic            tick;
   logic            tick_run;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      ss_lag_det #(
         .FB_W      (FB_W),
         .REF_MV    (REF_MV),
         .MARGIN_MV (MARGIN_MV),
         .WIN_MV    (WIN_MV)
      ) u_det (
         .ramp_mv (ramp_q),
         .fb_mv   (fb_mv[c*FB_W +: FB_W]),
         .lag     (lag_vec[c]),
         .in_win  (win_vec[c])
      );
   end

   always_comb begin
      checking = (state_q == SS_RAMP) || (state_q == SS_SETTLE);
      fault    = main_ok && checking && (|lag_vec);
      tick_run = main_ok && (state_q == SS_RAMP) && !fault;
   end

   ss_tick_gen #(
      .TICK_CYCLES (TICK_CYCLES)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (tick_run),
      .tick  (tick)
   );

   ss_sat_cnt #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (fault),
      .count (hiccup_cnt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= SS_IDLE;
         ramp_q    <= '0;
         restart_q <= 1'b0;
      end else begin
         restart_q <= 1'b0;
         if (!main_ok) begin
            state_q <= SS_IDLE;
            ramp_q  <= '0;
         end else begin
            unique case (state_q)
               SS_IDLE: begin
                  state_q <= SS_RAMP;
                  ramp_q  <= '0;
               end
               SS_RAMP: begin
                  if (fault) begin
                     ramp_q    <= '0;
                     restart_q <= 1'b1;
                  end else if (tick) begin
                     ramp_q <= ramp_q + STEP_C;
                     if (ramp_q == LAST_STEP) begin
                        state_q <= SS_SETTLE;
                     end
                  end
               end
               SS_SETTLE: begin
                  if (fault) begin
                     state_q   <= SS_RAMP;
                     ramp_q    <= '0;
                     restart_q <= 1'b1;
                  end else if (&win_vec) begin
                     state_q <= SS_HOLD;
                  end
               end
               SS_HOLD: begin
                  state_q <= SS_HOLD;
               end
               default: begin
                  state_q <= SS_IDLE;
                  ramp_q  <= '0;
               end
            endcase
         end
      end
   end

   assign ramp_mv     = ramp_q;
   assign soft_active = checking;
   assign regulated   = (state_q == SS_HOLD);
   assign restart     = restart_q;
endmodule

// File: rtl/ss_hiccup_checker.sv
module ss_hiccup_checker #(
   parameter int FB_W    = 12,
   parameter int REF_MV  = 800,
   parameter int STEP_MV = 8,
   parameter int CNT_W   = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             main_ok,
   input logic [FB_W-1:0]  ramp_mv,
   input logic             soft_active,
   input logic             regulated,
   input logic             restart,
   input logic [CNT_W-1:0] hiccup_cnt
);
   localparam logic [FB_W-1:0]  REF_C  = FB_W'(REF_MV);
   localparam logic [FB_W-1:0]  STEP_C = FB_W'(STEP_MV);
   localparam logic [CNT_W-1:0] TOP    = '1;

   AST_IDLE_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !main_ok |=> (ramp_mv == '0 && !soft_active && !regulated && !restart)); // R8
   AST_RAMP_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
      ramp_mv <= REF_C); // R3
   AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_active && !restart) |->
         (ramp_mv == $past(ramp_mv) || ramp_mv == $past(ramp_mv) + STEP_C)); // R3
   AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      restart |-> (ramp_mv == '0 && soft_active)); // R4
   AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !restart); // R9
   AST_CNT_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
      hiccup_cnt >= $past(hiccup_cnt)); // R5
   AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      (hiccup_cnt == TOP) |=> (hiccup_cnt == TOP)); // R5
   AST_REG_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(regulated) |-> ($past(soft_active) && $past(ramp_mv) == REF_C)); // R6
   AST_REG_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      regulated |-> (ramp_mv == REF_C && !restart)); // R7
   AST_REG_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (regulated && main_ok) |=> regulated); // R7
endmodule

bind ss_hiccup_supervisor ss_hiccup_checker #(
   .FB_W    (FB_W),
   .REF_MV  (REF_MV),
   .STEP_MV (STEP_MV),
   .CNT_W   (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .main_ok     (main_ok),
   .ramp_mv     (ramp_mv),
   .soft_active (soft_active),
   .regulated   (regulated),
   .restart     (restart),
   .hiccup_cnt  (hiccup_cnt)
);

// File: tb/ss_hiccup_supervisor_bench.sv
module ss_hiccup_supervisor_bench;
   localparam int NUM_CH    = 2;
   localparam int FB_W      = 12;
   localparam int CLK_KHZ   = 100000;
   localparam int RAMP_US   = 1;
   localparam int REF_MV    = 800;
   localparam int STEP_MV   = 50;
   localparam int MARGIN_MV = 100;
   localparam int WIN_MV    = 20;
   localparam int CNT_W     = 3;
   localparam int STEPS     = REF_MV / STEP_MV;
   localparam int TICK      = (CLK_KHZ * RAMP_US) / (1000 * STEPS);
   localparam int CNT_TOP   = (1 << CNT_W) - 1;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   main_ok = 1'b0;
   logic [NUM_CH*FB_W-1:0] fb_mv = '0;
   logic [FB_W-1:0]        ramp_mv;
   logic                   soft_active;
   logic                   regulated;
   logic                   restart;
   logic [CNT_W-1:0]       hiccup_cnt;

   int n_chk  = 0;
   int n_fail = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   ss_hiccup_supervisor #(
      .NUM_CH (NUM_CH), .FB_W (FB_W), .CLK_KHZ (CLK_KHZ), .RAMP_US (RAMP_US),
      .REF_MV (REF_MV), .STEP_MV (STEP_MV), .MARGIN_MV (MARGIN_MV),
      .WIN_MV (WIN_MV), .CNT_W (CNT_W)
   ) u_ss_hiccup_supervisor (
      .clk (clk), .rst_n (rst_n), .main_ok (main_ok), .fb_mv (fb_mv),
      .ramp_mv (ramp_mv), .soft_active (soft_active), .regulated (regulated),
      .restart (restart), .hiccup_cnt (hiccup_cnt)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: run hung, actual=%0d expected<=%0d", cycles, 100000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_fb(input int f0, input int f1);
      fb_mv = {FB_W'(f1), FB_W'(f0)};
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0; main_ok = 1'b0; set_fb(0, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      apply_reset();
      chk(ramp_mv == 0 && !soft_active && !regulated && !restart, "R1 outputs idle",
          {ramp_mv, soft_active, regulated, restart}, 0);
      chk(hiccup_cnt == 0, "R1 hiccup_cnt", hiccup_cnt, 0);
   endtask

   task automatic t_idle();
      bit bad = 0;
      apply_reset();
      set_fb(0, 0);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (ramp_mv != 0 || soft_active || regulated) bad = 1;
         if (i == 10) set_fb(REF_MV, 3);
      end
      chk(!bad, "R2 idle while main_ok low", bad, 0);
   endtask

   task automatic t_ramp_and_hold();
      int  soft_n = 0;
      int  rises  = 0;
      int  prev   = 0;
      bit  bad_step = 0;
      bit  bad_hold = 0;
      int  guard  = 0;
      apply_reset();
      set_fb(REF_MV, REF_MV);
      main_ok = 1'b1;
      @(negedge clk);
      chk(soft_active && ramp_mv == 0, "R3 start at zero", ramp_mv, 0);
      while (!regulated && guard < 1000) begin
         if (soft_active) soft_n++;
         if (ramp_mv != prev) begin
            if (ramp_mv != prev + STEP_MV) bad_step = 1;
            rises++;
         end
         prev = ramp_mv;
         guard++;
         @(negedge clk);
      end
      chk(!bad_step, "R3 step size", bad_step, 0);
      chk(rises == STEPS, "R3 step count", rises, STEPS);
      chk(soft_n == STEPS * TICK + 1, "R3/R6 ramp plus settle cycles", soft_n, STEPS * TICK + 1);
      chk(regulated && !soft_active && ramp_mv == REF_MV, "R6 regulated at reference", ramp_mv, REF_MV);
      set_fb(0, 0);
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (!regulated || ramp_mv != REF_MV || restart) bad_hold = 1;
      end
      chk(!bad_hold, "R7 feedback ignored in regulation", bad_hold, 0);
      chk(hiccup_cnt == 0, "R7 no hiccup counted", hiccup_cnt, 0);
      main_ok = 1'b0;
      @(negedge clk);
      chk(!regulated && !soft_active && ramp_mv == 0, "R8 drop from regulation", ramp_mv, 0);
   endtask

   task automatic t_fault(input int ch, input int fb_low, input int exp_peak);
      int peak  = 0;
      int guard = 0;
      apply_reset();
      if (ch == 0) set_fb(fb_low, REF_MV); else set_fb(REF_MV, fb_low);
      main_ok = 1'b1;
      @(negedge clk);
      while (!restart && guard < 1000) begin
         if (ramp_mv > peak) peak = ramp_mv;
         guard++;
         @(negedge clk);
      end
      chk(peak == exp_peak, "R4 ramp peak before restart", peak, exp_peak);
      chk(restart && ramp_mv == 0 && soft_active, "R4 ramp restarted at zero", ramp_mv, 0);
      chk(hiccup_cnt == 1, "R5 one hiccup counted", hiccup_cnt, 1);
      @(negedge clk);
      chk(!restart, "R9 restart one cycle", restart, 0);
      main_ok = 1'b0;
      @(negedge clk);
      chk(ramp_mv == 0 && !soft_active && !restart, "R8 drop during ramp", ramp_mv, 0);
      chk(hiccup_cnt == 1, "R5 count kept on drop", hiccup_cnt, 1);
   endtask

   task automatic t_settle_window();
      apply_reset();
      set_fb(REF_MV - WIN_MV - 1, REF_MV);
      main_ok = 1'b1;
      repeat (STEPS * TICK + 10) @(negedge clk);
      chk(!regulated && soft_active && ramp_mv == REF_MV, "R6 outside window waits", regulated, 0);
      set_fb(REF_MV - WIN_MV, REF_MV + WIN_MV);
      @(negedge clk);
      chk(regulated, "R6 window limits accepted", regulated, 1);
      apply_reset();
      set_fb(REF_MV - WIN_MV - 1, REF_MV - WIN_MV - 1);
      main_ok = 1'b1;
      repeat (STEPS * TICK + 10) @(negedge clk);
      set_fb(REF_MV, REF_MV - MARGIN_MV);
      @(negedge clk);
      chk(restart && ramp_mv == 0 && soft_active, "R4 lag during settle restarts", ramp_mv, 0);
      chk(hiccup_cnt == 1, "R5 settle hiccup counted", hiccup_cnt, 1);
   endtask

   task automatic t_saturate();
      int guard = 0;
      apply_reset();
      set_fb(0, REF_MV);
      main_ok = 1'b1;
      repeat (20 * (2 * TICK + 1)) @(negedge clk);
      chk(hiccup_cnt == CNT_TOP, "R5 saturates", hiccup_cnt, CNT_TOP);
      set_fb(REF_MV, REF_MV);
      while (!regulated && guard < 1000) begin
         guard++;
         @(negedge clk);
      end
      chk(regulated, "R6 recovery after faults", regulated, 1);
      chk(hiccup_cnt == CNT_TOP, "R5 saturated count held", hiccup_cnt, CNT_TOP);
   endtask

   initial begin
      t_reset();
      t_idle();
      t_ramp_and_hold();
      t_fault(0, 0, MARGIN_MV);
      t_fault(1, 1, MARGIN_MV + STEP_MV);
      t_settle_window();
      t_saturate();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule